// File: doc/BRIEF.md
# Framebuffer Writeback Engine

This block captures one frame of streamed pixels and writes it to memory in raster order, one word per pixel. Software programs a destination base, a line stride and the frame size through a small 32-bit register bus, then writes the control register to launch a frame. While the frame runs, each accepted pixel leaves as a word write request. Its address is the line base plus four times the column. The line base begins at the aligned destination pointer and advances by the aligned stride at every line end.

The engine reports whether a frame is running. It keeps a count of finished lines, can raise an interrupt once it falls idle, and can stop a frame early on request. An optional mode issues a fresh frame-start request to the pixel source each time a frame ends. A power-down bit holds the engine off.

Top module: `fbwb_engine`

## Requirements
- R1: Registers decode on word addresses (address bits 1:0 must be zero): 0x00 destination pointer, 0x04 stride in bytes, 0x08 size (height in bits 31:16, width in bits 15:0), 0x0C control, 0x10 progress. The pointer, stride and size read back exactly as written.
- R2: Control reads 0x54 in bits 31:24 and 2'b01 in bits 23:22. Bit 0 (start) always reads 0.
- R3: A control write with bit 0 set, bit 14 clear and bit 21 clear, made while idle, sets busy (control bit 1) in the next cycle and pulses frameStartReq for one cycle.
- R4: While busy, memValid equals pixValid and pixReady equals memReady, and both are 0 when idle. The word for column c of line n goes to (pointer with bits 1:0 cleared) + n*(stride with bits 3:0 cleared) + 4*c. Data is passed through unchanged and all byte strobes are 1.
- R5: A line ends after width pixels are accepted, or on an accepted pixel carrying pixEol. The frame ends when the last line ends (height lines) or on an accepted pixel carrying pixEof. Busy clears in the next cycle.
- R6: Progress reads the number of lines ended since the last start.
- R7: With control bit 2 set, irq rises when the engine goes idle through a frame end or an abort. Writing bit 2 as 0 drops irq, and a new start also clears it.
- R8: Writing control bit 14 while busy clears busy in the next cycle, and no memory request follows. Bit 14 written while idle has no effect on busy.
- R9: While control bit 21 is set, including in the same write, start is ignored. Bit 21 reads back as written.
- R10: With control bit 15 set, frameStartReq pulses in the cycle after a frame ends.
- R11: A start written while busy is ignored: the frame, its addresses and its progress carry on.
- R12: When an abort write lands in the same cycle as the frame's final accepted pixel, that pixel is written and counted in progress, and irq is raised once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 5 | Register byte address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| pixValid | input | 1 | Pixel valid |
| pixReady | output | 1 | Pixel accepted when high with pixValid |
| pixData | input | 32 | Pixel word |
| pixEol | input | 1 | Pixel is last of its line |
| pixEof | input | 1 | Pixel is last of the frame |
| memValid | output | 1 | Write request valid |
| memReady | input | 1 | Memory accepts the request |
| memAddr | output | 32 | Write byte address |
| memData | output | 32 | Write data |
| memStrb | output | 4 | Byte strobes |
| irq | output | 1 | Idle interrupt |
| frameStartReq | output | 1 | One-cycle frame-start request to the source |

## Verification
The tricky overlap is an abort write arriving in the very cycle that the final pixel of a frame is handed to memory. The bench forces this by driving a register write to control with bit 14 set, together with a valid pixel and a ready memory, on one clock edge. It then expects busy low, progress counting the last line, a single raised irq and a frame-start pulse from the end-of-frame mode. A start written mid-frame is provoked in the same way, and the bench judges it by addresses and progress that carry on without a break.

// File: rtl/fbwb_pkg.sv
package fbwb_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned DIM_W = 16;
  localparam logic [7:0] ID_TAG = 8'h54;
  localparam logic [1:0] ID_REV = 2'b01;

  // control field positions
  localparam int unsigned C_GO    = 0;
  localparam int unsigned C_BUSY  = 1;
  localparam int unsigned C_IRQEN = 2;
  localparam int unsigned C_ABORT = 14;
  localparam int unsigned C_VSEOF = 15;
  localparam int unsigned C_PDOWN = 21;

  typedef enum logic [2:0] {
    IDX_PTR   = 3'd0,
    IDX_PITCH = 3'd1,
    IDX_DIM   = 3'd2,
    IDX_CTRL  = 3'd3,
    IDX_PROG  = 3'd4
  } reg_idx_e;

  typedef struct packed {
    logic start;
    logic run;
  } fbwb_strobe_t;
endpackage

// File: rtl/fbwb_ctrl.sv
module fbwb_ctrl
  import fbwb_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [4:0]          regAddr,
  input  logic                regWrEn,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  input  logic                frameEnd,
  input  logic [DIM_W-1:0]    progress,
  output fbwb_strobe_t        strobe,
  output logic [REG_W-1:0]    baseAddr,
  output logic [REG_W-1:0]    lineStep,
  output logic [DIM_W-1:0]    width,
  output logic [DIM_W-1:0]    height,
  output logic                irq,
  output logic                frameStartReq
);
  logic [REG_W-1:0] ptrReg, pitchReg, dimReg;
  logic irqEn, vsEof, pDown, busy, irqPend, vsReq;
  logic regHit, ctrlWr, startNow, abortNow, irqEnNext;
  reg_idx_e idx;

  assign regHit    = (regAddr[1:0] == 2'b00);
  assign idx       = reg_idx_e'(regAddr[4:2]);
  assign ctrlWr    = regWrEn && regHit && (idx == IDX_CTRL);
  assign startNow  = ctrlWr && regWrData[C_GO] && !regWrData[C_ABORT]
                     && !regWrData[C_PDOWN] && !busy;
  assign abortNow  = ctrlWr && regWrData[C_ABORT] && busy;
  assign irqEnNext = ctrlWr ? regWrData[C_IRQEN] : irqEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrReg <= '0; pitchReg <= '0; dimReg <= '0;
      irqEn <= 1'b0; vsEof <= 1'b0; pDown <= 1'b0;
      busy <= 1'b0; irqPend <= 1'b0; vsReq <= 1'b0;
    end else begin
      if (regWrEn && regHit && idx == IDX_PTR)   ptrReg   <= regWrData;
      if (regWrEn && regHit && idx == IDX_PITCH) pitchReg <= regWrData;
      if (regWrEn && regHit && idx == IDX_DIM)   dimReg   <= regWrData;
      if (ctrlWr) begin
        irqEn <= regWrData[C_IRQEN];
        vsEof <= regWrData[C_VSEOF];
        pDown <= regWrData[C_PDOWN];
      end
      if (startNow)                  busy <= 1'b1;
      else if (abortNow || frameEnd) busy <= 1'b0;
      if (startNow)                                          irqPend <= 1'b0;
      else if (busy && (abortNow || frameEnd) && irqEnNext)  irqPend <= 1'b1;
      else if (!irqEnNext)                                   irqPend <= 1'b0;
      vsReq <= startNow || (frameEnd && vsEof);
    end
  end

  always_comb begin
    regRdData = '0;
    if (regHit) begin
      case (idx)
        IDX_PTR:   regRdData = ptrReg;
        IDX_PITCH: regRdData = pitchReg;
        IDX_DIM:   regRdData = dimReg;
        IDX_CTRL:  regRdData = {ID_TAG, ID_REV, pDown, 5'b0, vsEof, 12'b0,
                                irqEn, busy, 1'b0};
        IDX_PROG:  regRdData = {{(REG_W-DIM_W){1'b0}}, progress};
        default:   regRdData = '0;
      endcase
    end
  end

  assign strobe.start  = startNow;
  assign strobe.run    = busy;
  assign baseAddr      = ptrReg & ~32'h3;
  assign lineStep      = pitchReg & ~32'hF;
  assign width         = dimReg[DIM_W-1:0];
  assign height        = dimReg[REG_W-1:REG_W-DIM_W];
  assign irq           = irqPend;
  assign frameStartReq = vsReq;

  a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    startNow |=> busy && frameStartReq);
  a_r8_abort_clears_busy: assert property (@(posedge clk) disable iff (!rstN)
    abortNow |=> !busy);
  a_r11_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    busy && !abortNow && !frameEnd |=> busy);
  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> irqEn);
  a_r10_vstart_after_end: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd && vsEof |=> frameStartReq);
endmodule

// File: rtl/fbwb_datapath.sv
module fbwb_datapath
  import fbwb_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  fbwb_strobe_t        strobe,
  input  logic [REG_W-1:0]    baseAddr,
  input  logic [REG_W-1:0]    lineStep,
  input  logic [DIM_W-1:0]    width,
  input  logic [DIM_W-1:0]    height,
  input  logic                pixValid,
  output logic                pixReady,
  input  logic [DATA_W-1:0]   pixData,
  input  logic                pixEol,
  input  logic                pixEof,
  output logic                memValid,
  input  logic                memReady,
  output logic [REG_W-1:0]    memAddr,
  output logic [DATA_W-1:0]   memData,
  output logic [DATA_W/8-1:0] memStrb,
  output logic [DIM_W-1:0]    lineCount,
  output logic                frameEnd
);
  localparam int unsigned BYTES = DATA_W / 8;
  localparam int unsigned SHIFT = $clog2(BYTES);

  logic [DIM_W-1:0] col;
  logic [REG_W-1:0] lineBase;
  logic accept, lastCol, lastLine, lineEnd;

  assign accept   = strobe.run && pixValid && memReady;
  assign lastCol  = (col == width - 1'b1);
  assign lastLine = (lineCount == height - 1'b1);
  assign lineEnd  = accept && (lastCol || pixEol);
  assign frameEnd = accept && ((lineEnd && lastLine) || pixEof);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      col <= '0; lineCount <= '0; lineBase <= '0;
    end else if (strobe.start) begin
      col <= '0; lineCount <= '0; lineBase <= baseAddr;
    end else if (accept) begin
      if (lineEnd) begin
        col       <= '0;
        lineCount <= lineCount + 1'b1;
        lineBase  <= lineBase + lineStep;
      end else begin
        col <= col + 1'b1;
      end
    end
  end

  assign pixReady = strobe.run && memReady;
  assign memValid = strobe.run && pixValid;
  assign memAddr  = lineBase + (REG_W'(col) << SHIFT);
  assign memData  = pixData;
  assign memStrb  = {BYTES{1'b1}};

  a_r6_progress_step: assert property (@(posedge clk) disable iff (!rstN)
    lineEnd |=> lineCount == $past(lineCount) + 1'b1);
  a_r6_progress_still: assert property (@(posedge clk) disable iff (!rstN)
    !accept && !strobe.start |=> $stable(lineCount));
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start |-> !memValid && !pixReady);
endmodule

// File: rtl/fbwb_engine.sv
module fbwb_engine
  import fbwb_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [4:0]          regAddr,
  input  logic                regWrEn,
  input  logic [31:0]         regWrData,
  output logic [31:0]         regRdData,
  input  logic                pixValid,
  output logic                pixReady,
  input  logic [DATA_W-1:0]   pixData,
  input  logic                pixEol,
  input  logic                pixEof,
  output logic                memValid,
  input  logic                memReady,
  output logic [31:0]         memAddr,
  output logic [DATA_W-1:0]   memData,
  output logic [DATA_W/8-1:0] memStrb,
  output logic                irq,
  output logic                frameStartReq
);
  fbwb_strobe_t strobe;
  logic [REG_W-1:0] baseAddr, lineStep;
  logic [DIM_W-1:0] width, height, lineCount;
  logic frameEnd;

  fbwb_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .frameEnd(frameEnd),
    .progress(lineCount), .strobe(strobe), .baseAddr(baseAddr),
    .lineStep(lineStep), .width(width), .height(height), .irq(irq),
    .frameStartReq(frameStartReq)
  );

  fbwb_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .baseAddr(baseAddr),
    .lineStep(lineStep), .width(width), .height(height),
    .pixValid(pixValid), .pixReady(pixReady), .pixData(pixData),
    .pixEol(pixEol), .pixEof(pixEof), .memValid(memValid),
    .memReady(memReady), .memAddr(memAddr), .memData(memData),
    .memStrb(memStrb), .lineCount(lineCount), .frameEnd(frameEnd)
  );
endmodule

// File: tb/fbwb_engine_tb_top.sv
module fbwb_engine_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic [4:0] regAddr = 5'h0C;
  logic regWrEn = 1'b0;
  logic [31:0] regWrData = '0, regRdData;
  logic pixValid = 1'b0, pixReady, pixEol = 1'b0, pixEof = 1'b0;
  logic [31:0] pixData = '0;
  logic memValid, memReady = 1'b0;
  logic [31:0] memAddr, memData;
  logic [3:0] memStrb;
  logic irq, frameStartReq;

  int tests = 0, fails = 0, dataCtr = 0;
  bit done = 0, checking = 0;

  // behavioural reference state
  logic [31:0] mPtr = 0, mPitch = 0, mDim = 0, mBase = 0;
  logic [15:0] mCol = 0, mLines = 0;
  logic mBusy = 0, mIrq = 0, mVs = 0, mEi = 0, mVsEof = 0, mPd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fbwb_engine dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .pixValid(pixValid),
    .pixReady(pixReady), .pixData(pixData), .pixEol(pixEol), .pixEof(pixEof),
    .memValid(memValid), .memReady(memReady), .memAddr(memAddr),
    .memData(memData), .memStrb(memStrb), .irq(irq),
    .frameStartReq(frameStartReq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] modelRead(input logic [4:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    case (a[4:2])
      3'd0: return mPtr;
      3'd1: return mPitch;
      3'd2: return mDim;
      3'd3: return {8'h54, 2'b01, mPd, 5'b0, mVsEof, 12'b0, mEi, mBusy, 1'b0};
      3'd4: return {16'b0, mLines};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic acc, lEnd, fEnd, cw, st, ab, eiN;
    if (!rstN) begin
      mPtr = 0; mPitch = 0; mDim = 0; mBase = 0; mCol = 0; mLines = 0;
      mBusy = 0; mIrq = 0; mVs = 0; mEi = 0; mVsEof = 0; mPd = 0;
    end else begin
      acc  = mBusy && pixValid && memReady;
      lEnd = acc && (mCol == mDim[15:0] - 16'd1 || pixEol);
      fEnd = acc && ((lEnd && mLines == mDim[31:16] - 16'd1) || pixEof);
      cw   = regWrEn && regAddr == 5'h0C;
      st   = cw && regWrData[0] && !regWrData[14] && !regWrData[21] && !mBusy;
      ab   = cw && regWrData[14] && mBusy;
      eiN  = cw ? regWrData[2] : mEi;
      mVs  = st || (fEnd && mVsEof);
      if (st) mIrq = 0;
      else if (mBusy && (ab || fEnd) && eiN) mIrq = 1;
      else if (!eiN) mIrq = 0;
      if (st) begin
        mCol = 0; mLines = 0; mBase = mPtr & ~32'h3;
      end else if (acc) begin
        if (lEnd) begin mCol = 0; mLines++; mBase += mPitch & ~32'hF; end
        else mCol++;
      end
      if (st) mBusy = 1; else if (ab || fEnd) mBusy = 0;
      if (regWrEn && regAddr == 5'h00) mPtr = regWrData;
      if (regWrEn && regAddr == 5'h04) mPitch = regWrData;
      if (regWrEn && regAddr == 5'h08) mDim = regWrData;
      if (cw) begin mEi = regWrData[2]; mVsEof = regWrData[15]; mPd = regWrData[21]; end
    end
  end

  // per-cycle comparison against the model
  always begin
    @(negedge clk); #1;
    if (checking && !done) begin
      check(memValid == (mBusy && pixValid), "R4 memValid", 32'(memValid), 32'(mBusy && pixValid));
      check(pixReady == (mBusy && memReady), "R4 pixReady", 32'(pixReady), 32'(mBusy && memReady));
      if (memValid) begin
        check(memAddr == mBase + {mCol, 2'b00}, "R4 memAddr", memAddr, mBase + {mCol, 2'b00});
        check(memData == pixData && memStrb == 4'hF, "R4 data/strb", memData, pixData);
      end
      check(irq == mIrq, "R7 irq", 32'(irq), 32'(mIrq));
      check(frameStartReq == mVs, "R10 frameStartReq", 32'(frameStartReq), 32'(mVs));
      check(regRdData == modelRead(regAddr), "R1 readback", regRdData, modelRead(regAddr));
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 0; regAddr = 5'h0C;
  endtask

  task automatic rdChk(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); regAddr = a; #1;
    check(regRdData == exp, tag, regRdData, exp);
  endtask

  task automatic pushPix(input int n, input bit eolLast, input bit eofLast, input bit stall);
    int sent = 0;
    for (int cyc = 0; cyc < 400 && sent < n; cyc++) begin
      @(negedge clk);
      pixValid = 1; pixData = 32'hA500_0000 + dataCtr;
      pixEol = eolLast && (sent == n - 1);
      pixEof = eofLast && (sent == n - 1);
      memReady = stall ? (cyc % 3 != 1) : 1'b1;
      #1;
      if (pixReady) begin sent++; dataCtr++; end
    end
    @(negedge clk); pixValid = 0; pixEol = 0; pixEof = 0; memReady = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    checking = 1;
    // reset state
    rdChk(5'h0C, 32'h5440_0000, "R2 reset control/id");
    check(irq == 0 && frameStartReq == 0, "R2 reset outputs", 32'(irq), 0);
    rdChk(5'h10, 0, "R6 reset progress");
    // programming
    wr(5'h00, 32'h0000_1003);
    wr(5'h04, 32'h0000_004A);
    wr(5'h08, 32'h0003_0004);
    rdChk(5'h00, 32'h0000_1003, "R1 pointer readback");
    rdChk(5'h04, 32'h0000_004A, "R1 pitch readback");
    rdChk(5'h08, 32'h0003_0004, "R1 dim readback");
    rdChk(5'h02, 32'h0, "R1 misaligned address");
    // full frame with stalls, irq and vstart-at-end
    wr(5'h0C, 32'h0000_8005);
    rdChk(5'h0C, 32'h5440_8006, "R3 busy after start, R2 go self-clears");
    pushPix(12, 0, 0, 1);
    rdChk(5'h10, 3, "R6 progress after full frame, R5 end by size");
    rdChk(5'h0C, 32'h5440_8004, "R5 busy clears");
    check(irq == 1, "R7 irq on idle", 32'(irq), 1);
    wr(5'h0C, 32'h0000_8000);
    check(irq == 0, "R7 irq ack", 32'(irq), 0);
    // R11 start while busy, then R8 abort
    wr(5'h0C, 32'h0000_0005);
    pushPix(2, 0, 0, 0);
    wr(5'h0C, 32'h0000_0005);
    pushPix(3, 0, 0, 0);
    rdChk(5'h10, 1, "R11 progress continues after ignored start");
    wr(5'h0C, 32'h0000_4004);
    rdChk(5'h0C, 32'h5440_0004, "R8 abort clears busy");
    check(irq == 1, "R7 irq after abort", 32'(irq), 1);
    pushPix(1, 0, 0, 0);
    rdChk(5'h10, 1, "R8 no writes after abort");
    wr(5'h0C, 32'h0000_4000);
    rdChk(5'h0C, 32'h5440_0000, "R8 idle abort no effect");
    check(irq == 0, "R7 irq drops with enable clear", 32'(irq), 0);
    // R5 early end-of-line then end-of-frame
    wr(5'h0C, 32'h0000_0001);
    pushPix(2, 1, 0, 0);
    pushPix(1, 0, 1, 0);
    rdChk(5'h10, 1, "R5 eol ends line early");
    rdChk(5'h0C, 32'h5440_0000, "R5 eof ends frame");
    // R9 power-down blocks start
    wr(5'h0C, 32'h0020_0001);
    rdChk(5'h0C, 32'h5460_0000, "R9 start ignored while powered down");
    wr(5'h0C, 32'h0020_0000);
    wr(5'h0C, 32'h0000_0001);
    rdChk(5'h0C, 32'h5440_0002, "R9 start after power-up");
    pushPix(12, 0, 0, 0);
    rdChk(5'h10, 3, "R6 second full frame");
    // R12 abort coincides with final pixel
    wr(5'h08, 32'h0001_0002);
    wr(5'h0C, 32'h0000_8005);
    pushPix(1, 0, 0, 0);
    @(negedge clk);
    pixValid = 1; memReady = 1; pixData = 32'h5A5A_0001;
    regWrEn = 1; regAddr = 5'h0C; regWrData = 32'h0000_4004;
    @(negedge clk);
    pixValid = 0; memReady = 0; regWrEn = 0;
    #1;
    check(frameStartReq == 1, "R12 end-of-frame request with abort", 32'(frameStartReq), 1);
    rdChk(5'h10, 1, "R12 final pixel counted");
    rdChk(5'h0C, 32'h5440_0004, "R12 idle after overlap");
    check(irq == 1, "R12 irq raised", 32'(irq), 1);
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule